// File: doc/BRIEF.md
# RV32I Instruction Decode Unit

This unit turns one 32-bit base-integer instruction word into the control bundle a single-cycle core needs. It provides three register indices, a register-write strobe, memory read and write strobes, a source select for each ALU operand, a write-back source select and a fully sign-extended immediate. The unit is purely combinational, so the outputs follow the instruction in the same cycle and need no clock, reset or handshake. The fetch stage presents a word and the datapath uses the bundle before the next clock edge.

The decoder handles every base format (register, immediate, store, branch, upper-immediate and jump), including the loads and stores. Upper-immediate instructions have their first read index forced to x0, and each operand has its own source select. As a result, LUI runs through the ordinary adder as x0 plus the immediate, and AUIPC runs as the instruction address plus the immediate.

Some indices belong to fields that a format does not use. These are driven to zero, which keeps the register-file ports quiet. Opcodes outside the base integer set yield an all-zero bundle, so they cannot write anything.

Top module: `rv_idu`

## Requirements
- R1: `rs1_addr` is instr[19:15] for register, immediate, load, store, branch and JALR words, and 0 otherwise. `rs2_addr` is instr[24:20] for register, store and branch words, and 0 otherwise. `rd_addr` is instr[11:7] whenever `rd_we` is 1, and 0 otherwise.
- R2: For LUI (opcode 0110111) and AUIPC (opcode 0010111), `rs1_addr` is 0, `op2_sel` is 1 (immediate), `rd_we` is 1, `wb_sel` is 0, and `imm` is {instr[31:12], 12'b0}. `op1_sel` is 0 (register) for LUI and 1 (instruction address) for AUIPC.
- R3: For a register-register word (opcode 0110011), both operand selects are 0 (register), `rd_we` is 1, `wb_sel` is 0 (ALU) and `imm` is 0.
- R4: For a load (opcode 0000011), `mem_rd_en` and `rd_we` are 1 and `mem_wr_en` is 0. `op1_sel` is 0, `op2_sel` is 1, `wb_sel` is 1 (memory) and `imm` is instr[31:20] sign-extended.
- R5: For a store (opcode 0100011), `mem_wr_en` is 1, while `rd_we` and `mem_rd_en` are 0. `op1_sel` is 0, `op2_sel` is 1, and `imm` is {instr[31:25], instr[11:5+2]} (that is, instr[11:7] in the low five bits) sign-extended.
- R6: For a branch (opcode 1100011), no write enable is asserted, `op1_sel` is 1 and `op2_sel` is 1. `imm` is {instr[31], instr[7], instr[30:25], instr[11:8], 0} sign-extended.
- R7: For JAL (opcode 1101111) and JALR (opcode 1100111), `op1_sel` is 1, `op2_sel` is 1, `rd_we` is 1 and `wb_sel` is 2 (link). The JAL `imm` is {instr[31], instr[19:12], instr[20], instr[30:21], 0} sign-extended. The JALR `imm` is instr[31:20] sign-extended.
- R8: For an immediate-arithmetic word (opcode 0010011), `op1_sel` is 0, `op2_sel` is 1, `rd_we` is 1, `wb_sel` is 0 and `imm` is instr[31:20] sign-extended.
- R9: Any other opcode, such as the system opcode 1110011 or an all-zero or all-one word, drives every output to 0.
- R10: `mem_rd_en` and `mem_wr_en` are never 1 together. Whenever `op1_sel` selects the instruction address, `op2_sel` selects the immediate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 32 | Instruction word to decode |
| rs1_addr | output | 5 | First register-file read index |
| rs2_addr | output | 5 | Second register-file read index |
| rd_addr | output | 5 | Destination register index |
| rd_we | output | 1 | Register-file write enable |
| mem_rd_en | output | 1 | Data-memory read enable |
| mem_wr_en | output | 1 | Data-memory write enable |
| op1_sel | output | 1 | ALU operand 1 source: 0 register, 1 instruction address |
| op2_sel | output | 1 | ALU operand 2 source: 0 register, 1 immediate |
| wb_sel | output | 2 | Write-back source: 0 ALU, 1 memory, 2 link address |
| imm | output | 32 | Sign-extended immediate |

## Verification
The unit holds no state, so a fault in its opcode table or immediate wiring shows at the ports in the same cycle the word is presented, with no latency to wait out. A wrong table entry shows up as a stray write strobe, a swapped operand select or an unmasked index. A miswired immediate shows up as a wrong bit position, most visibly when the sign bit is set. For this reason, every format is exercised with both a positive and a negative immediate, and with register indices that differ from one another.

// File: rtl/rv_idu_pkg.sv
package rv_idu_pkg;

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OPREG  = 7'b0110011;

  typedef enum logic [0:0] {SRC1_REG = 1'b0, SRC1_PC  = 1'b1} src1_e;
  typedef enum logic [0:0] {SRC2_REG = 1'b0, SRC2_IMM = 1'b1} src2_e;
  typedef enum logic [1:0] {WB_ALU = 2'd0, WB_MEM = 2'd1, WB_LINK = 2'd2} wb_e;
  typedef enum logic [2:0] {
    IMK_NONE, IMK_I, IMK_S, IMK_B, IMK_U, IMK_J
  } imm_kind_e;

  typedef struct packed {
    logic      wr_reg;
    logic      rd_mem;
    logic      wr_mem;
    src1_e     src1;
    src2_e     src2;
    wb_e       wb;
    logic      uses_a;
    logic      uses_b;
    imm_kind_e kind;
  } ctrl_t;

endpackage

// File: rtl/rv_idu_ctrl.sv
module rv_idu_ctrl
  import rv_idu_pkg::*;
(
  input  logic [6:0] opcode,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '{wr_reg: 1'b0, rd_mem: 1'b0, wr_mem: 1'b0, src1: SRC1_REG,
             src2: SRC2_REG, wb: WB_ALU, uses_a: 1'b0, uses_b: 1'b0,
             kind: IMK_NONE};
    unique case (opcode)
      OPC_OPREG: begin
        ctrl.wr_reg = 1'b1;
        ctrl.uses_a = 1'b1;
        ctrl.uses_b = 1'b1;
      end
      OPC_OPIMM: begin
        ctrl.wr_reg = 1'b1;
        ctrl.uses_a = 1'b1;
        ctrl.src2   = SRC2_IMM;
        ctrl.kind   = IMK_I;
      end
      OPC_LOAD: begin
        ctrl.wr_reg = 1'b1;
        ctrl.rd_mem = 1'b1;
        ctrl.uses_a = 1'b1;
        ctrl.src2   = SRC2_IMM;
        ctrl.wb     = WB_MEM;
        ctrl.kind   = IMK_I;
      end
      OPC_STORE: begin
        ctrl.wr_mem = 1'b1;
        ctrl.uses_a = 1'b1;
        ctrl.uses_b = 1'b1;
        ctrl.src2   = SRC2_IMM;
        ctrl.kind   = IMK_S;
      end
      OPC_BRANCH: begin
        ctrl.uses_a = 1'b1;
        ctrl.uses_b = 1'b1;
        ctrl.src1   = SRC1_PC;
        ctrl.src2   = SRC2_IMM;
        ctrl.kind   = IMK_B;
      end
      OPC_LUI: begin
        ctrl.wr_reg = 1'b1;
        ctrl.src2   = SRC2_IMM;
        ctrl.kind   = IMK_U;
      end
      OPC_AUIPC: begin
        ctrl.wr_reg = 1'b1;
        ctrl.src1   = SRC1_PC;
        ctrl.src2   = SRC2_IMM;
        ctrl.kind   = IMK_U;
      end
      OPC_JAL: begin
        ctrl.wr_reg = 1'b1;
        ctrl.src1   = SRC1_PC;
        ctrl.src2   = SRC2_IMM;
        ctrl.wb     = WB_LINK;
        ctrl.kind   = IMK_J;
      end
      OPC_JALR: begin
        ctrl.wr_reg = 1'b1;
        ctrl.uses_a = 1'b1;
        ctrl.src1   = SRC1_PC;
        ctrl.src2   = SRC2_IMM;
        ctrl.wb     = WB_LINK;
        ctrl.kind   = IMK_I;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rv_idu_imm.sv
module rv_idu_imm
  import rv_idu_pkg::*;
#(
  parameter int ILEN = 32,
  parameter int XLEN = 32
) (
  input  logic [ILEN-1:0] instr,
  input  imm_kind_e       kind,
  output logic [XLEN-1:0] imm
);

  localparam int SIGN = ILEN - 1;
  logic [ILEN-1:0] base;
  logic            s;

  assign s = instr[SIGN];

  always_comb begin
    unique case (kind)
      IMK_I:   base = {{20{s}}, instr[31:20]};
      IMK_S:   base = {{20{s}}, instr[31:25], instr[11:7]};
      IMK_B:   base = {{19{s}}, s, instr[7], instr[30:25], instr[11:8], 1'b0};
      IMK_U:   base = {instr[31:12], 12'b0};
      IMK_J:   base = {{11{s}}, s, instr[19:12], instr[20], instr[30:21], 1'b0};
      default: base = '0;
    endcase
  end

  generate
    if (XLEN == ILEN) begin : g_same
      assign imm = base;
    end else begin : g_ext
      assign imm = {{(XLEN-ILEN){base[ILEN-1]}}, base};
    end
  endgenerate

endmodule

// File: rtl/rv_idu.sv
module rv_idu
  import rv_idu_pkg::*;
#(
  parameter int ILEN = 32,
  parameter int XLEN = 32,
  parameter int RAW  = 5
) (
  input  logic [ILEN-1:0] instr_word,
  output logic [RAW-1:0]  rs1_addr,
  output logic [RAW-1:0]  rs2_addr,
  output logic [RAW-1:0]  rd_addr,
  output logic            rd_we,
  output logic            mem_rd_en,
  output logic            mem_wr_en,
  output logic            op1_sel,
  output logic            op2_sel,
  output logic [1:0]      wb_sel,
  output logic [XLEN-1:0] imm
);

  localparam int OPC_W  = 7;
  localparam int RD_LO  = OPC_W;
  localparam int RS1_LO = RD_LO + RAW + 3;
  localparam int RS2_LO = RS1_LO + RAW;

  ctrl_t ctrl;

  rv_idu_ctrl u_ctrl (
    .opcode (instr_word[OPC_W-1:0]),
    .ctrl   (ctrl)
  );

  rv_idu_imm #(.ILEN(ILEN), .XLEN(XLEN)) u_imm (
    .instr (instr_word),
    .kind  (ctrl.kind),
    .imm   (imm)
  );

  assign rs1_addr  = ctrl.uses_a ? instr_word[RS1_LO +: RAW] : '0;
  assign rs2_addr  = ctrl.uses_b ? instr_word[RS2_LO +: RAW] : '0;
  assign rd_addr   = ctrl.wr_reg ? instr_word[RD_LO +: RAW]  : '0;
  assign rd_we     = ctrl.wr_reg;
  assign mem_rd_en = ctrl.rd_mem;
  assign mem_wr_en = ctrl.wr_mem;
  assign op1_sel   = ctrl.src1;
  assign op2_sel   = ctrl.src2;
  assign wb_sel    = ctrl.wb;

endmodule

// File: rtl/rv_idu_chk.sv
module rv_idu_chk #(
  parameter int ILEN = 32,
  parameter int XLEN = 32,
  parameter int RAW  = 5
) (
  input logic [ILEN-1:0] instr_word,
  input logic [RAW-1:0]  rs1_addr,
  input logic [RAW-1:0]  rs2_addr,
  input logic [RAW-1:0]  rd_addr,
  input logic            rd_we,
  input logic            mem_rd_en,
  input logic            mem_wr_en,
  input logic            op1_sel,
  input logic            op2_sel,
  input logic [1:0]      wb_sel,
  input logic [XLEN-1:0] imm
);

  logic known;
  assign known = !$isunknown(instr_word);

  always_comb begin
    if (known) begin
      // R10
      mem_excl_chk: assert (!(mem_rd_en && mem_wr_en));
      // R10
      pc_imm_pair_chk: assert (!op1_sel || op2_sel);
      // R5
      store_no_wb_chk: assert (!mem_wr_en || !rd_we);
      // R4
      load_wb_chk: assert (!mem_rd_en || (rd_we && wb_sel == 2'd1));
      // R1
      rd_mask_chk: assert (rd_we || rd_addr == '0);
      // R2
      upper_rs1_chk: assert (!(instr_word[4:0] == 5'b10111) || rs1_addr == '0);
      // R9
      idle_chk: assert (instr_word[1:0] == 2'b11 ||
                        (imm == '0 && rs2_addr == '0 && wb_sel == 2'd0));
    end
  end

endmodule

bind rv_idu rv_idu_chk #(.ILEN(ILEN), .XLEN(XLEN), .RAW(RAW)) u_chk (
  .instr_word (instr_word),
  .rs1_addr   (rs1_addr),
  .rs2_addr   (rs2_addr),
  .rd_addr    (rd_addr),
  .rd_we      (rd_we),
  .mem_rd_en  (mem_rd_en),
  .mem_wr_en  (mem_wr_en),
  .op1_sel    (op1_sel),
  .op2_sel    (op2_sel),
  .wb_sel     (wb_sel),
  .imm        (imm)
);

// File: tb/tb_rv_idu.sv
module tb_rv_idu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] instr_word = 32'h0;
  logic [4:0]  rs1_addr, rs2_addr, rd_addr;
  logic        rd_we, mem_rd_en, mem_wr_en, op1_sel, op2_sel;
  logic [1:0]  wb_sel;
  logic [31:0] imm;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rv_idu dut (
    .instr_word (instr_word),
    .rs1_addr   (rs1_addr),
    .rs2_addr   (rs2_addr),
    .rd_addr    (rd_addr),
    .rd_we      (rd_we),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .op1_sel    (op1_sel),
    .op2_sel    (op2_sel),
    .wb_sel     (wb_sel),
    .imm        (imm)
  );

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // order: rs1 rs2 rd we mrd mwr op1 op2 wb imm
  task automatic apply(string req, logic [31:0] w, logic [4:0] e1, logic [4:0] e2,
                       logic [4:0] ed, logic ewe, logic emr, logic emw,
                       logic eo1, logic eo2, logic [1:0] ewb, logic [31:0] eim);
    @(posedge clk);
    instr_word = w;
    @(negedge clk);
    cmp(req, "rs1_addr", 32'(rs1_addr), 32'(e1));
    cmp(req, "rs2_addr", 32'(rs2_addr), 32'(e2));
    cmp(req, "rd_addr", 32'(rd_addr), 32'(ed));
    cmp(req, "rd_we", 32'(rd_we), 32'(ewe));
    cmp(req, "mem_rd_en", 32'(mem_rd_en), 32'(emr));
    cmp(req, "mem_wr_en", 32'(mem_wr_en), 32'(emw));
    cmp(req, "op1_sel", 32'(op1_sel), 32'(eo1));
    cmp(req, "op2_sel", 32'(op2_sel), 32'(eo2));
    cmp(req, "wb_sel", 32'(wb_sel), 32'(ewb));
    cmp(req, "imm", imm, eim);
  endtask

  task automatic t_idle_r9();
    apply("R9", 32'h0000_0000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0);
    apply("R9", 32'h0000_0073, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0);
    apply("R9", 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0);
  endtask

  task automatic t_store_r5();
    apply("R5", 32'h00a0_2223, 0, 10, 0, 0, 0, 1, 0, 1, 0, 32'h4);
    apply("R5", 32'hFE32_2C23, 4, 3, 0, 0, 0, 1, 0, 1, 0, 32'hFFFF_FFF8);
  endtask

  task automatic t_upper_r2();
    apply("R2", 32'h0000_22b7, 0, 0, 5, 1, 0, 0, 0, 1, 0, 32'h0000_2000);
    apply("R2", 32'h1234_5397, 0, 0, 7, 1, 0, 0, 1, 1, 0, 32'h1234_5000);
    apply("R2", 32'hFFFF_F0B7, 0, 0, 1, 1, 0, 0, 0, 1, 0, 32'hFFFF_F000);
  endtask

  task automatic t_reg_r3();
    apply("R3", 32'h0020_81b3, 1, 2, 3, 1, 0, 0, 0, 0, 0, 32'h0);
  endtask

  task automatic t_load_r4();
    apply("R4", 32'h00c2_a503, 5, 0, 10, 1, 1, 0, 0, 1, 1, 32'hC);
  endtask

  task automatic t_branch_r6();
    apply("R6", 32'h0020_8163, 1, 2, 0, 0, 0, 0, 1, 1, 0, 32'h2);
    apply("R6", 32'hFE00_0EE3, 0, 0, 0, 0, 0, 0, 1, 1, 0, 32'hFFFF_FFFC);
  endtask

  task automatic t_jump_r7();
    apply("R7", 32'h0080_00EF, 0, 0, 1, 1, 0, 0, 1, 1, 2, 32'h8);
    apply("R7", 32'hFFDF_F06F, 0, 0, 0, 1, 0, 0, 1, 1, 2, 32'hFFFF_FFFC);
    apply("R7", 32'hFFF2_80E7, 5, 0, 1, 1, 0, 0, 1, 1, 2, 32'hFFFF_FFFF);
  endtask

  task automatic t_opimm_r8();
    apply("R8", 32'hFFB3_8313, 7, 0, 6, 1, 0, 0, 0, 1, 0, 32'hFFFF_FFFB);
  endtask

  // R1 and R10 are covered by the index and enable fields of every vector above
  initial begin
    t_idle_r9();
    t_store_r5();
    t_upper_r2();
    t_reg_r3();
    t_load_r4();
    t_branch_r6();
    t_jump_r7();
    t_opimm_r8();
    t_idle_r9();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule